// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Controller

This block runs enhanced-parallel-port (EPP) address and data cycles on an 8-bit bidirectional peripheral bus when software accesses two register offsets. Offset 3 runs an address cycle. Offset 4 runs a data cycle of 1, 2 or 4 bytes. A multi-byte word travels on the byte bus lowest byte first. A cycle starts only when the control register holds exactly the legal pattern for its direction. An access that does not match that pattern causes no bus activity. A read of that kind returns all ones for its width.

Each byte raises a strobe and holds it until the peripheral raises its wait line. A watchdog counter limits how long the strobe may wait. If the counter runs out, the transfer stops at once, the remaining bytes are skipped, and a sticky timeout flag is set. That flag appears as bit 0 of the status register. Software clears it by writing the status register with bit 0 set. The block also holds the data latch and the control register, both written with change detection. A write that repeats the stored value is dropped.

Requests enter on a valid/ready channel and one request is handled at a time. Each accepted request, read or write, produces exactly one response on a valid/ready channel. A response is held, with its data stable, until it is taken. No new request is accepted until the response has been taken.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset the control register reads 0xCC and status bit 0 reads 0. Both strobes are low, `write_n` is high and `req_ready` is high.
- R2: A write at offset 3 or 4 runs a bus cycle only when control bits {5,3,2,1,0} equal 0,0,1,0,0. Otherwise no strobe rises and the timeout flag is unchanged.
- R3: A read at offset 3 or 4 runs a bus cycle only when control bits {5,3,2,1,0} equal 1,0,1,0,0. Otherwise no strobe rises and the response data is all ones in the low access-width bytes and zero above.
- R4: An address cycle drives `addr_stb`; a data cycle drives `data_stb`; the two are never high together. During each write byte `write_n` is low and `per_dout` carries that byte.
- R5: `req_size` sets the width of an offset-4 cycle: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. Bytes move lowest first. Read byte k lands in `rsp_rdata[8k+7:8k]`. Offset 3 always moves one byte.
- R6: A strobe stays high until `per_wait` is sampled high, then drops for at least one cycle. A wait seen on the last of the `TMO_LIMIT` strobe cycles counts as success.
- R7: If `per_wait` stays low for `TMO_LIMIT` strobe cycles, the cycle ends and the timeout flag sets and stays set. No further byte of that access is strobed, and read bytes not received return 0xFF.
- R8: Writing offset 1 with bit 0 set clears the timeout flag. Writing offset 1 with bit 0 clear leaves it unchanged.
- R9: A read of offset 1 returns `per_status[7:1]` in bits 7:1 and the timeout flag in bit 0.
- R10: A control write (offset 2) that changes bit 5 pulses `dir_chg` for one cycle, and `bus_dir` follows bit 5.
- R11: A write to offset 0 or offset 2 whose value equals the stored one is dropped: `data_upd` or `ctrl_upd` does not pulse. A changed value pulses it once. Outside EPP writes, `per_dout` shows the data latch.
- R12: Control bits 7 and 6 always read as 1.
- R13: `req_ready` is low while `busy` is high. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_rdata` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 3 | Register offset (0 data, 1 status, 2 control, 3 EPP address, 4 EPP data) |
| req_size | input | 2 | Byte-count code for offset 4 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid (done) |
| rsp_ready | input | 1 | Response taken when high together with valid |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| busy | output | 1 | A request is in progress |
| per_status | input | 8 | Peripheral status lines |
| per_wait | input | 1 | Peripheral wait/handshake line |
| per_din | input | 8 | Byte bus input |
| per_dout | output | 8 | Byte bus output |
| ctrl_lines | output | 4 | Control bits 3:0 driven to the peripheral |
| bus_dir | output | 1 | Byte bus direction (1 = input) |
| dir_chg | output | 1 | One-cycle pulse on a direction change |
| data_upd | output | 1 | One-cycle pulse when the data latch changes |
| ctrl_upd | output | 1 | One-cycle pulse when the control register changes |
| data_stb | output | 1 | Data strobe, active high |
| addr_stb | output | 1 | Address strobe, active high |
| write_n | output | 1 | Low during write cycles |

## Verification
Two events can land on the same clock edge. One is the wait response completing a byte. The other is the watchdog reaching its limit. The bench's peripheral model raises wait after a programmable delay, so the bench can place the wait on exactly the last counting cycle and, in a second run, one cycle later. The first run must complete the byte with the flag clear. The second must end the access with 0xFF data and the flag set. A partial-response run stops answering halfway through a 4-byte read, and the bench judges the skipped bytes from the number of strobes it observed.

// File: rtl/epp_ctl_pkg.sv
package epp_ctl_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_STB  = 2'd1,
    S_GAP  = 2'd2,
    S_RSP  = 2'd3
  } seq_state_t;

  localparam logic [2:0] OFF_DATA  = 3'd0;
  localparam logic [2:0] OFF_STAT  = 3'd1;
  localparam logic [2:0] OFF_CTRL  = 3'd2;
  localparam logic [2:0] OFF_EADDR = 3'd3;
  localparam logic [2:0] OFF_EDATA = 3'd4;

  localparam logic [7:0] CTRL_RST   = 8'hCC;
  localparam logic [7:0] CTRL_FIXED = 8'hC0;
  localparam logic [7:0] CTRL_MASK  = 8'h2F;
  localparam logic [7:0] EPP_WR_OK  = 8'h04;
  localparam logic [7:0] EPP_RD_OK  = 8'h24;
endpackage

// File: rtl/epp_regs.sv
module epp_regs
  import epp_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       wr,
  input  logic [2:0] off,
  input  logic [7:0] wbyte,
  input  logic       fail,
  input  logic [7:0] per_status,
  input  logic [7:0] per_din,
  output logic [7:0] ctrl_q,
  output logic [7:0] dataw_q,
  output logic       tmo_q,
  output logic [7:0] rd_byte,
  output logic       data_upd,
  output logic       ctrl_upd,
  output logic       dir_chg
);
  logic [7:0] ctrl_nx;
  assign ctrl_nx = wbyte | CTRL_FIXED;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      dataw_q  <= 8'hFF;
      tmo_q    <= 1'b0;
      data_upd <= 1'b0;
      ctrl_upd <= 1'b0;
      dir_chg  <= 1'b0;
    end else begin
      data_upd <= 1'b0;
      ctrl_upd <= 1'b0;
      dir_chg  <= 1'b0;
      if (fail) tmo_q <= 1'b1;
      if (acc && wr) begin
        case (off)
          OFF_DATA: if (wbyte != dataw_q) begin
            dataw_q  <= wbyte;
            data_upd <= 1'b1;
          end
          OFF_STAT: if (wbyte[0]) tmo_q <= 1'b0;
          OFF_CTRL: if (ctrl_nx != ctrl_q) begin
            ctrl_q   <= ctrl_nx;
            ctrl_upd <= 1'b1;
            dir_chg  <= ctrl_nx[5] ^ ctrl_q[5];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (off)
      OFF_DATA: rd_byte = ctrl_q[5] ? per_din : dataw_q;
      OFF_STAT: rd_byte = {per_status[7:1], tmo_q};
      OFF_CTRL: rd_byte = ctrl_q;
      default:  rd_byte = 8'hFF;
    endcase
  end
endmodule

// File: rtl/epp_wdog.sv
module epp_wdog #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);
endmodule

// File: rtl/epp_seq.sv
module epp_seq
  import epp_ctl_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int SZW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             wr,
  input  logic [2:0]       off,
  input  logic [SZW-1:0]   size,
  input  logic [BUS_W-1:0] wdata,
  input  logic [7:0]       ctrl,
  input  logic [7:0]       rd_byte,
  input  logic             per_wait,
  input  logic [7:0]       per_din,
  input  logic             expire,
  input  logic             rsp_ready,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_rdata,
  output logic             busy,
  output logic             run,
  output logic             fail,
  output logic             drive_en,
  output logic [7:0]       byte_out,
  output logic             data_stb,
  output logic             addr_stb,
  output logic             write_n
);
  localparam int NB = BUS_W / 8;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  seq_state_t       st;
  logic [IW-1:0]    idx, last;
  logic             is_addr, is_wr;
  logic [BUS_W-1:0] wbuf, rbuf;
  logic [IW-1:0]    nbm1;
  logic [BUS_W-1:0] ones;
  logic             is_epp, legal;
  int               nbytes;

  always_comb begin
    nbytes = 1;
    if (off == OFF_EDATA) nbytes = int'(1) << size;
    if (nbytes > NB) nbytes = NB;
    nbm1 = IW'(nbytes - 1);
    for (int b = 0; b < NB; b++)
      ones[b*8 +: 8] = (b <= int'(nbm1)) ? 8'hFF : 8'h00;
    is_epp = (off == OFF_EADDR) || (off == OFF_EDATA);
    legal  = wr ? ((ctrl & CTRL_MASK) == EPP_WR_OK)
                : ((ctrl & CTRL_MASK) == EPP_RD_OK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      last    <= '0;
      is_addr <= 1'b0;
      is_wr   <= 1'b0;
      wbuf    <= '0;
      rbuf    <= '0;
    end else begin
      case (st)
        S_IDLE: if (acc) begin
          wbuf    <= wdata;
          is_wr   <= wr;
          is_addr <= (off == OFF_EADDR);
          idx     <= '0;
          last    <= nbm1;
          if (is_epp && legal) begin
            st   <= S_STB;
            rbuf <= wr ? '0 : ones;
          end else begin
            st <= S_RSP;
            if (wr)          rbuf <= '0;
            else if (is_epp) rbuf <= ones;
            else             rbuf <= {{(BUS_W-8){1'b0}}, rd_byte};
          end
        end
        S_STB: begin
          if (per_wait) begin
            if (!is_wr) rbuf[int'(idx)*8 +: 8] <= per_din;
            st <= S_GAP;
          end else if (expire) begin
            st <= S_RSP;
          end
        end
        S_GAP: begin
          if (idx == last) st <= S_RSP;
          else begin
            idx <= idx + 1'b1;
            st  <= S_STB;
          end
        end
        S_RSP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign rsp_valid = (st == S_RSP);
  assign rsp_rdata = rbuf;
  assign run       = (st == S_STB);
  assign fail      = run && !per_wait && expire;
  assign drive_en  = ((st == S_STB) || (st == S_GAP)) && is_wr;
  assign byte_out  = wbuf[int'(idx)*8 +: 8];
  assign data_stb  = run && !is_addr;
  assign addr_stb  = run && is_addr;
  assign write_n   = !drive_en;
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_ctl_pkg::*;
#(
  parameter int TMO_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [2:0]  req_offset,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        busy,
  input  logic [7:0]  per_status,
  input  logic        per_wait,
  input  logic [7:0]  per_din,
  output logic [7:0]  per_dout,
  output logic [3:0]  ctrl_lines,
  output logic        bus_dir,
  output logic        dir_chg,
  output logic        data_upd,
  output logic        ctrl_upd,
  output logic        data_stb,
  output logic        addr_stb,
  output logic        write_n
);
  logic       acc, fail, run, tmo_expire, drive_en, tmo;
  logic [7:0] ctrl_q, dataw_q, rd_byte, byte_out;

  assign acc = req_valid && req_ready;

  epp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wr(req_write), .off(req_offset),
    .wbyte(req_wdata[7:0]), .fail(fail), .per_status(per_status),
    .per_din(per_din), .ctrl_q(ctrl_q), .dataw_q(dataw_q), .tmo_q(tmo),
    .rd_byte(rd_byte), .data_upd(data_upd), .ctrl_upd(ctrl_upd),
    .dir_chg(dir_chg)
  );

  epp_wdog #(.LIMIT(TMO_LIMIT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .run(run), .expire(tmo_expire)
  );

  epp_seq #(.BUS_W(32), .SZW(2)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wr(req_write), .off(req_offset),
    .size(req_size), .wdata(req_wdata), .ctrl(ctrl_q), .rd_byte(rd_byte),
    .per_wait(per_wait), .per_din(per_din), .expire(tmo_expire),
    .rsp_ready(rsp_ready), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .busy(busy), .run(run), .fail(fail),
    .drive_en(drive_en), .byte_out(byte_out), .data_stb(data_stb),
    .addr_stb(addr_stb), .write_n(write_n)
  );

  assign per_dout   = drive_en ? byte_out : dataw_q;
  assign ctrl_lines = ctrl_q[3:0];
  assign bus_dir    = ctrl_q[5];
endmodule

// File: rtl/epp_cycle_ctrl_chk.sv
module epp_cycle_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [2:0]  req_offset,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        busy,
  input logic        data_stb,
  input logic        addr_stb,
  input logic        write_n,
  input logic        per_wait,
  input logic        bus_dir,
  input logic        dir_chg,
  input logic        tmo,
  input logic        expire
);
  logic clr_req;
  assign clr_req = req_valid && req_ready && req_write &&
                   (req_offset == 3'd1) && req_wdata[0];

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_stb && addr_stb));
  a_r4_write_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !write_n |-> busy);
  a_r6_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb && !per_wait && !expire) |=> data_stb);
  a_r6_strobe_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_stb || addr_stb) && per_wait) |=> !(data_stb || addr_stb));
  a_r7_fail_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_stb || addr_stb) && !per_wait && expire) |=> (tmo && rsp_valid));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && !clr_req) |=> tmo);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !tmo);
  a_r10_dir_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dir != $past(bus_dir)) |-> dir_chg);
  a_r13_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  a_r13_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind epp_cycle_ctrl epp_cycle_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_offset(req_offset), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .busy(busy), .data_stb(data_stb), .addr_stb(addr_stb), .write_n(write_n),
  .per_wait(per_wait), .bus_dir(bus_dir), .dir_chg(dir_chg), .tmo(tmo),
  .expire(tmo_expire)
);

// File: tb/epp_cycle_ctrl_test.sv
`timescale 1ns/1ps
module epp_cycle_ctrl_test;
  localparam int LIM = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [2:0] req_offset = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic [7:0] per_status = 8'hA5, per_din = 8'h00;
  logic per_wait = 0;
  logic req_ready, rsp_valid, busy, bus_dir, dir_chg, data_upd, ctrl_upd;
  logic data_stb, addr_stb, write_n;
  logic [31:0] rsp_rdata;
  logic [7:0] per_dout;
  logic [3:0] ctrl_lines;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int delay = 1, ans_limit = 1000, bcnt = 0, scnt = 0, nstb = 0;
  int n_dupd = 0, n_cupd = 0, n_dchg = 0;
  logic [7:0] rd_base = 8'h80;
  logic [7:0] wlog [0:7];
  logic alog [0:7];
  logic wnlog [0:7];
  logic stb_prev = 0;

  always #2.5 clk = ~clk;

  epp_cycle_ctrl #(.TMO_LIMIT(LIM)) uut (.*);

  // peripheral model and event monitor
  always @(negedge clk) begin
    cyc++;
    if (data_upd) n_dupd++;
    if (ctrl_upd) n_cupd++;
    if (dir_chg)  n_dchg++;
    if ((data_stb || addr_stb) && !stb_prev) nstb++;
    stb_prev = data_stb || addr_stb;
    if (data_stb || addr_stb) begin
      if (!per_wait && bcnt < ans_limit && scnt == delay) begin
        per_wait = 1'b1;
        per_din  = rd_base + 8'(bcnt);
        if (bcnt < 8) begin
          wlog[bcnt]  = per_dout;
          alog[bcnt]  = addr_stb;
          wnlog[bcnt] = write_n;
        end
        bcnt++;
      end
      scnt++;
    end else begin
      scnt = 0;
      per_wait = 1'b0;
    end
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [2:0] off, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_offset = off; req_size = sz; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reset_log();
    bcnt = 0; nstb = 0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    @(negedge clk);
    chk("R1 req_ready", 32'(req_ready), 1);
    chk("R1 strobes", {30'd0, data_stb, addr_stb}, 0);
    chk("R1 write_n", 32'(write_n), 1);
    xfer(0, 3'd2, 0, 0, r); chk("R1 R12 control reset", r, 32'hCC);
    xfer(0, 3'd1, 0, 0, r); chk("R1 R9 status", r, 32'hA4);
  endtask

  task automatic t_illegal();
    logic [31:0] r;
    reset_log();
    xfer(1, 3'd4, 2, 32'h12345678, r); chk("R2 ignored write strobes", 32'(nstb), 0);
    xfer(0, 3'd1, 0, 0, r); chk("R2 timeout untouched", 32'(r[0]), 0);
    xfer(0, 3'd4, 1, 0, r); chk("R3 illegal 2B read", r, 32'h0000FFFF);
    xfer(0, 3'd4, 2, 0, r); chk("R3 illegal 4B read", r, 32'hFFFFFFFF);
    xfer(0, 3'd3, 2, 0, r); chk("R3 R5 illegal addr read", r, 32'h000000FF);
    chk("R3 no strobes", 32'(nstb), 0);
  endtask

  task automatic t_regs();
    logic [31:0] r;
    int c0, d0;
    c0 = n_cupd; d0 = n_dupd;
    xfer(1, 3'd2, 0, 32'h04, r);
    xfer(0, 3'd2, 0, 0, r); chk("R12 control bits 7:6", r, 32'hC4);
    chk("R11 ctrl change pulses", 32'(n_cupd - c0), 1);
    xfer(1, 3'd2, 0, 32'h04, r); chk("R11 equal ctrl dropped", 32'(n_cupd - c0), 1);
    xfer(1, 3'd0, 0, 32'h5A, r); xfer(1, 3'd0, 0, 32'h5A, r);
    chk("R11 equal data dropped", 32'(n_dupd - d0), 1);
    chk("R11 idle dout", 32'(per_dout), 32'h5A);
    chk("R12 ctrl lines", 32'(ctrl_lines), 32'h4);
  endtask

  task automatic t_write();
    logic [31:0] r;
    reset_log(); delay = 2;
    xfer(1, 3'd3, 0, 32'hAB, r);
    chk("R4 addr byte", 32'(wlog[0]), 32'hAB);
    chk("R4 addr strobe used", 32'(alog[0]), 1);
    chk("R4 write_n low", 32'(wnlog[0]), 0);
    reset_log();
    xfer(1, 3'd4, 2, 32'h44332211, r);
    chk("R5 4B write count", 32'(bcnt), 4);
    chk("R5 LSB first", {wlog[3], wlog[2], wlog[1], wlog[0]}, 32'h44332211);
    chk("R4 data strobe used", 32'(alog[2]), 0);
    chk("R6 strobes drop between bytes", 32'(nstb), 4);
    reset_log();
    xfer(1, 3'd3, 2, 32'h00007766, r); chk("R5 offset3 one byte", 32'(bcnt), 1);
    xfer(0, 3'd1, 0, 0, r); chk("R2 no timeout", 32'(r[0]), 0);
  endtask

  task automatic t_read();
    logic [31:0] r;
    int d0;
    d0 = n_dchg;
    xfer(1, 3'd2, 0, 32'h24, r);
    chk("R10 dir pulse", 32'(n_dchg - d0), 1);
    chk("R10 bus_dir", 32'(bus_dir), 1);
    reset_log(); rd_base = 8'h80;
    xfer(0, 3'd4, 1, 0, r); chk("R5 2B read", r, 32'h00008180);
    reset_log(); rd_base = 8'h10;
    xfer(0, 3'd4, 3, 0, r); chk("R5 size3 4B read", r, 32'h13121110);
    reset_log();
    xfer(1, 3'd4, 0, 32'h99, r); chk("R2 write with dir=1 ignored", 32'(nstb), 0);
  endtask

  task automatic t_edge();
    logic [31:0] r;
    reset_log(); rd_base = 8'h3C; delay = LIM - 1;
    xfer(0, 3'd4, 0, 0, r); chk("R6 wait on last cycle wins", r, 32'h3C);
    xfer(0, 3'd1, 0, 0, r); chk("R6 no timeout", 32'(r[0]), 0);
    reset_log(); delay = LIM;
    xfer(0, 3'd3, 0, 0, r); chk("R7 late wait fails", r, 32'hFF);
    per_status = 8'h00;
    xfer(0, 3'd1, 0, 0, r); chk("R7 R9 timeout in bit0", r, 32'h01);
    xfer(1, 3'd1, 0, 32'hFE, r);
    xfer(0, 3'd1, 0, 0, r); chk("R8 bit0 clear keeps flag", r, 32'h01);
    xfer(1, 3'd1, 0, 32'h01, r);
    per_status = 8'hFF;
    xfer(0, 3'd1, 0, 0, r); chk("R8 R9 cleared flag", r, 32'hFE);
  endtask

  task automatic t_partial();
    logic [31:0] r;
    reset_log(); rd_base = 8'h50; delay = 1; ans_limit = 2;
    xfer(0, 3'd4, 2, 0, r); chk("R7 partial read data", r, 32'hFFFF5150);
    chk("R7 remaining bytes skipped", 32'(nstb), 3);
    xfer(0, 3'd1, 0, 0, r); chk("R7 flag set", 32'(r[0]), 1);
    ans_limit = 1000;
    xfer(1, 3'd1, 0, 32'h01, r);
  endtask

  task automatic t_backpressure();
    logic [31:0] r;
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_offset = 3'd2;
    @(posedge clk); @(negedge clk); req_valid = 0;
    repeat (4) @(negedge clk);
    chk("R13 rsp held", 32'(rsp_valid), 1);
    chk("R13 rdata stable", rsp_rdata, 32'hE4);
    chk("R13 no accept while busy", 32'(req_ready), 0);
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    chk("R13 ready after take", 32'(req_ready), 1);
    xfer(0, 3'd0, 0, 0, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_illegal();
    t_regs();
    t_write();
    t_read();
    t_edge();
    t_partial();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule